// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `K`-bit operands over `K` clock cycles and returns a `2K`-bit product. Each cycle it examines one multiplier bit, starting from the least significant one. If that bit is set, it adds the multiplicand into the upper half of a running product register. In the same write it moves the register one place to the right. Bits that leave the upper half fall into the lower half, where they replace the multiplier bits already used. One add-and-shift therefore finishes in every clock.

A two-bit mode input selects how the operands are read. The choices are plain unsigned, two's-complement, and sign-and-magnitude. In two's-complement mode the final step, which handles the multiplier's sign bit, subtracts the multiplicand instead of adding it. In sign-and-magnitude mode the block multiplies the two magnitudes as unsigned numbers and sets the top product bit to the XOR of the two sign bits. A caller raises `start_i` while `ready_o` is high and then waits for the one-cycle `done_o` pulse. The product then stays on `product_o` until the next accepted start.

Top module: `shiftadd_multiplier`

## Requirements
- R1: A start is accepted on a rising clock edge where `start_i` and `ready_o` are both high. The mode and both operands are captured on that edge, and `ready_o` is low in the following cycle.
- R2: `done_o` goes high in the cycle that follows the K-th rising edge after the accepting edge. `ready_o` stays low from the accepting edge until that same edge.
- R3: `done_o` is high for exactly one cycle per accepted start, and `ready_o` is high in that cycle, so a new start may be accepted during it.
- R4: While the block is busy, `start_i`, `mode_i`, `mcand_i` and `mplier_i` have no effect. The product and its timing follow only the values captured at acceptance.
- R5: With mode code 2'b00, `product_o` equals the unsigned product of the two operands.
- R6: With mode code 2'b10, `product_o` equals the two's-complement product of the two operands, taken modulo 2^(2K).
- R7: With mode code 2'b01, the operand MSB is the sign and bits K-2..0 are the magnitude. `product_o[2K-2:0]` is the product of the magnitudes, and `product_o[2K-1]` is the XOR of the two signs, even when a magnitude is zero.
- R8: Mode code 2'b11 behaves exactly as mode code 2'b00.
- R9: While `ready_o` is high and no start is accepted, `product_o` does not change.
- R10: While `rst_n` is low, and for two rising edges after it is released, `ready_o` and `done_o` are low and `product_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| start_i | input | 1 | Request to begin a multiplication |
| mode_i | input | 2 | Operand format: 00 unsigned, 01 sign-and-magnitude, 10 two's-complement, 11 unsigned |
| mcand_i | input | K | Multiplicand |
| mplier_i | input | K | Multiplier |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle pulse marking a valid product |
| product_o | output | 2K | Product; held until the next accepted start |

## Verification
The bench drives every pair of 4-bit operands in the unsigned, two's-complement and sign-and-magnitude modes, plus a sweep in the spare mode code. Its main targets are the most negative operand and a multiplier of all ones in two's-complement mode. A design that added in the sign step, or that lost the sign on the right shift, would return a wrong upper half there. In sign-and-magnitude mode it includes zero magnitudes with a set sign, which expose a design that forces positive zero. It also sends new requests on the done cycle itself, which catches a one-cycle latency slip. On roughly a third of the operations it switches the inputs and holds start high while the block is busy. A block that relatched the operands or restarted its count would then give a different product or move `done_o`.

// File: rtl/shm_pkg.sv
package shm_pkg;

  // Operand format selector; the code values are part of the interface.
  typedef enum logic [1:0] {
    MODE_UNS     = 2'b00,
    MODE_SMAG    = 2'b01,
    MODE_TWOS    = 2'b10,
    MODE_UNS_ALT = 2'b11
  } shm_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } shm_state_e;

endpackage

// File: rtl/shm_rst_sync.sv
// Reset conditioner: asserts asynchronously, deasserts after STAGES clock edges.
module shm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/shm_ctrl.sv
// Sequencer: accepts a start, issues K step strobes, flags the last, pulses done.
module shm_ctrl
  import shm_pkg::*;
#(
  parameter int K = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);

  localparam int CW = (K > 2) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(K - 1);

  shm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;
  logic          idle;

  // Next-state logic
  always_comb begin
    idle    = (state_q == ST_IDLE);
    load_o  = idle & start_i & rst_n;
    step_o  = (state_q == ST_RUN);
    last_o  = step_o & (cnt_q == LAST_IDX);
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = load_o | step_o;
    if (load_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) begin
        state_d = ST_IDLE;
      end
    end
    done_d = last_o;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = idle & rst_n;
  assign done_o  = done_q;

endmodule

// File: rtl/shm_operand_prep.sv
// Maps raw operands to the form the datapath consumes for the selected mode.
module shm_operand_prep
  import shm_pkg::*;
#(
  parameter int K = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [K-1:0] mcand_i,
  input  logic [K-1:0] mplier_i,
  output logic [K-1:0] mcand_o,
  output logic [K-1:0] mplier_o,
  output logic         twos_o,
  output logic         smag_o,
  output logic         sign_o
);

  shm_mode_e mode;

  always_comb begin
    mode     = shm_mode_e'(mode_i);
    mcand_o  = mcand_i;
    mplier_o = mplier_i;
    twos_o   = 1'b0;
    smag_o   = 1'b0;
    sign_o   = 1'b0;
    unique case (mode)
      MODE_TWOS: begin
        twos_o = 1'b1;
      end
      MODE_SMAG: begin
        smag_o   = 1'b1;
        sign_o   = mcand_i[K-1] ^ mplier_i[K-1];
        mcand_o  = {1'b0, mcand_i[K-2:0]};
        mplier_o = {1'b0, mplier_i[K-2:0]};
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/shm_datapath.sv
// Partial-product register with the right shift wired into its load path.
module shm_datapath #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         last_i,
  input  logic [K-1:0] mcand_i,
  input  logic [K-1:0] mplier_i,
  input  logic         twos_i,
  input  logic         smag_i,
  input  logic         sign_i,
  output logic [2*K-1:0] product_o
);

  localparam int PW = 2 * K;

  logic [K-1:0] mc_q, mc_d;
  logic [K-1:0] hi_q, hi_d;
  logic [K-1:0] lo_q, lo_d;
  logic         twos_q, smag_q, sign_q;
  logic         pp_en, op_en;

  logic [K:0]   ext_hi, ext_mc, addend, sum;
  logic         sub, cin;

  // Adder plus folded shift
  always_comb begin
    ext_hi = {twos_q & hi_q[K-1], hi_q};
    ext_mc = {twos_q & mc_q[K-1], mc_q};
    sub    = twos_q & last_i;
    if (lo_q[0]) begin
      addend = sub ? ~ext_mc : ext_mc;
      cin    = sub;
    end else begin
      addend = '0;
      cin    = 1'b0;
    end
    sum = ext_hi + addend + {{K{1'b0}}, cin};

    op_en = load_i;
    pp_en = load_i | step_i;
    mc_d  = mcand_i;
    if (load_i) begin
      hi_d = '0;
      lo_d = mplier_i;
    end else begin
      hi_d = sum[K:1];
      lo_d = {sum[0], lo_q[K-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      twos_q <= 1'b0;
      smag_q <= 1'b0;
      sign_q <= 1'b0;
    end else if (op_en) begin
      mc_q   <= mc_d;
      twos_q <= twos_i;
      smag_q <= smag_i;
      sign_q <= sign_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (pp_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_comb begin
    product_o = {hi_q, lo_q};
    if (smag_q) begin
      product_o[PW-1] = sign_q;
    end
  end

endmodule

// File: rtl/shiftadd_multiplier.sv
module shiftadd_multiplier #(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [K-1:0]   mcand_i,
  input  logic [K-1:0]   mplier_i,
  output logic           ready_o,
  output logic           done_o,
  output logic [2*K-1:0] product_o
);

  logic         rst_n_int;
  logic         load, step, last;
  logic [K-1:0] prep_mc, prep_mp;
  logic         prep_twos, prep_smag, prep_sign;

  shm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  shm_ctrl #(.K(K)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .ready_o (ready_o),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o)
  );

  shm_operand_prep #(.K(K)) u_prep (
    .mode_i   (mode_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .mcand_o  (prep_mc),
    .mplier_o (prep_mp),
    .twos_o   (prep_twos),
    .smag_o   (prep_smag),
    .sign_o   (prep_sign)
  );

  shm_datapath #(.K(K)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .mcand_i   (prep_mc),
    .mplier_i  (prep_mp),
    .twos_i    (prep_twos),
    .smag_i    (prep_smag),
    .sign_i    (prep_sign),
    .product_o (product_o)
  );

endmodule

// File: rtl/shm_checker.sv
module shm_checker
  import shm_pkg::*;
#(
  parameter int K = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [1:0]     mode_i,
  input logic [K-1:0]   mcand_i,
  input logic [K-1:0]   mplier_i,
  input logic           ready_o,
  input logic           done_o,
  input logic [2*K-1:0] product_o
);

  logic [K-1:0]   a_q, b_q;
  logic [1:0]     m_q;
  logic           run_q;
  int unsigned    lat_q;
  logic [2*K-1:0] exp_u, exp_t, exp_s, mag;
  logic           accept;

  assign accept = start_i & ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      m_q   <= '0;
      run_q <= 1'b0;
      lat_q <= 0;
    end else if (accept) begin
      a_q   <= mcand_i;
      b_q   <= mplier_i;
      m_q   <= mode_i;
      run_q <= 1'b1;
      lat_q <= 0;
    end else if (run_q) begin
      lat_q <= lat_q + 1;
      if (done_o) begin
        run_q <= 1'b0;
      end
    end
  end

  assign exp_u = {{K{1'b0}}, a_q} * {{K{1'b0}}, b_q};
  assign exp_t = {{K{a_q[K-1]}}, a_q} * {{K{b_q[K-1]}}, b_q};
  assign mag   = {{(K+1){1'b0}}, a_q[K-2:0]} * {{(K+1){1'b0}}, b_q[K-2:0]};
  assign exp_s = {a_q[K-1] ^ b_q[K-1], mag[2*K-2:0]};

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready_o); // R1
  AST_DONE_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q && lat_q == K)); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && lat_q < K) |-> !ready_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o); // R3
  AST_UNS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && m_q == MODE_UNS) |-> product_o == exp_u); // R5
  AST_TWOS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && m_q == MODE_TWOS) |-> product_o == exp_t); // R6
  AST_SMAG_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && m_q == MODE_SMAG) |-> product_o == exp_s); // R7
  AST_ALT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && m_q == MODE_UNS_ALT) |-> product_o == exp_u); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> $stable(product_o)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!ready_o && !done_o && product_o == '0)); // R10

endmodule

bind shiftadd_multiplier shm_checker #(.K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .ready_o   (ready_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/tb_shiftadd_multiplier.sv
module tb_shiftadd_multiplier;

  localparam int W    = 4;
  localparam int HALF = 1 << (W - 1);
  localparam int FULL = 1 << W;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [1:0]     mode_i;
  logic [W-1:0]   mcand_i;
  logic [W-1:0]   mplier_i;
  logic           ready_o;
  logic           done_o;
  logic [2*W-1:0] product_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  shiftadd_multiplier #(.K(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(int m, int a, int b);
    int sa, sb, p;
    case (m)
      2: begin
        sa = (a >= HALF) ? a - FULL : a;
        sb = (b >= HALF) ? b - FULL : b;
        p  = sa * sb;
        return p[2*W-1:0];
      end
      1: begin
        p = (a % HALF) * (b % HALF);
        if ((a >= HALF) != (b >= HALF)) p = p + (1 << (2*W - 1));
        return p[2*W-1:0];
      end
      default: begin
        p = a * b;
        return p[2*W-1:0];
      end
    endcase
  endfunction

  // Behavioural reference: when things happen and what the result is
  int             m_rel  = 0;
  bit             m_busy = 0;
  int             m_cnt  = 0;
  bit             m_done = 0;
  int             m_mode = 0;
  bit             m_junk = 0;
  logic [2*W-1:0] m_prod = '0;
  logic [2*W-1:0] m_next = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel  <= 0;
      m_busy <= 0;
      m_done <= 0;
      m_prod <= '0;
      m_cnt  <= 0;
      m_junk <= 0;
    end else begin
      if (m_rel < 2) m_rel <= m_rel + 1;
      if (m_busy) begin
        if (start_i) m_junk <= 1;
        if (m_cnt == 1) begin
          m_busy <= 0;
          m_done <= 1;
          m_prod <= m_next;
        end else begin
          m_cnt <= m_cnt - 1;
        end
      end else begin
        m_done <= 0;
        if (start_i && m_rel >= 2) begin
          m_busy <= 1;
          m_cnt  <= W;
          m_mode <= int'(mode_i);
          m_junk <= 0;
          m_next <= ref_mul(int'(mode_i), int'(mcand_i), int'(mplier_i));
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string prod_tag();
    if (m_rel < 2)  return "R10";
    if (m_junk)     return "R4";
    case (m_mode)
      1:       return "R7";
      2:       return "R6";
      3:       return "R8";
      default: return "R5";
    endcase
  endfunction

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(ready_o == (m_rel >= 2 && !m_busy), (m_rel < 2) ? "R10" : "R2",
          int'(ready_o), int'(m_rel >= 2 && !m_busy));
      chk(done_o == m_done, (m_rel < 2) ? "R10" : "R3", int'(done_o), int'(m_done));
      if (!m_busy) begin
        chk(product_o == m_prod, (m_done || m_rel < 2) ? prod_tag() : "R9",
            int'(product_o), int'(m_prod));
      end
    end
  end

  task automatic run(int m, int a, int b, bit junk);
    start_i  = 1'b1;
    mode_i   = 2'(m);
    mcand_i  = W'(a);
    mplier_i = W'(b);
    @(negedge clk);
    repeat (W - 1) begin
      start_i  = junk;
      mode_i   = ~2'(m);
      mcand_i  = ~W'(a);
      mplier_i = W'(b + 5);
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual no completion expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    mode_i   = 2'b00;
    mcand_i  = '0;
    mplier_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5 R6 R7: every operand pair in the three defined modes
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < FULL; a++) begin
        for (int b = 0; b < FULL; b++) begin
          run(m, a, b, ((a + b) % 3) == 0);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);  // R9 idle hold
      end
    end
    // R8: spare mode code
    for (int a = 0; a < FULL; a++) begin
      run(3, a, FULL - 1 - a, a[0]);
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule